// File: doc/BRIEF.md
# ULPI Link Transmit and Register Engine

This block is the link-side controller for the outbound half of a ULPI PHY connection. A local client hands it requests of three kinds: send a USB packet, write one or more PHY registers, or read one PHY register. The engine builds the ULPI command byte for the request and drives it on the 8-bit bus. It holds that byte until the PHY accepts it with `nxt`. It then streams payload bytes, each paced by `nxt`, ends the burst with a single `stp` cycle, and returns read data through a one-cycle result strobe.

The PHY owns the bus whenever `dir` is high, so the engine watches that signal all the time. The output enable drops as soon as `dir` rises. The engine waits one full cycle of low `dir` before it starts a new command. If the PHY takes the bus while a command is still waiting, the engine withdraws the command and leaves the request pending. When the bus is free again, it offers the same command once more.

The client keeps a request asserted until `req_ready` pulses, and it presents the first payload byte together with the request. Payload bytes are consumed on `dat_ready`. Board-level pad logic combines `ulpi_dout` and `ulpi_oe` into the tristate bus.

Top module: `ulpi_link_tx`

## Requirements
- R1: During reset `ulpi_dout` is 00h and `ulpi_oe`, `ulpi_stp`, `req_ready` and `rd_valid` are all low.
- R2: Bits 7:6 of the command byte hold the operation (01 send packet, 10 register write, 11 register read). For register operations, bits 5:0 hold the address. For a packet send, bits 5:4 are zero and bits 3:0 hold the PID. The PHY therefore forwards the PID, with its complement in the upper nibble, as the first packet byte.
- R3: A command byte stays unchanged on the bus in every cycle until a clock edge at which `nxt` is high and `dir` is low. `req_ready` is high in exactly that cycle.
- R4: A payload byte stays on the bus through cycles in which `nxt` is low. The next byte is presented only after an edge with `nxt` high, and `dat_ready` is high in that cycle. The PHY receives the bytes in the order supplied.
- R5: After the edge that accepts the byte flagged `dat_last`, `ulpi_stp` is high for exactly one cycle with the bus at 00h, and then the engine is idle.
- R6: In a multi-byte register write, the bytes reach the PHY in order, and the PHY stores them at consecutive addresses starting at the command's address.
- R7: After a read command is accepted, the engine waits for a cycle with `dir` high (the turnaround). It takes the bus value from the following cycle and presents it on `rd_data`, with `rd_valid` high for one cycle.
- R8: While `dir` is high, `ulpi_oe` is low in the same cycle. After any edge with `dir` high, `ulpi_oe` stays low and `ulpi_dout` is 00h for the following cycle.
- R9: A new command appears on the bus only if `dir` was low at the edge that launched it and at the edge before that.
- R10: If `dir` rises while a command waits for `nxt`, the engine drops the command without pulsing `req_ready`. After the bus is free again, it offers the identical command byte.
- R11: A request with operation 00 is consumed in its first cycle through `req_ready`, and nothing other than 00h appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the PHY |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending |
| req_op | input | 2 | Operation: 00 none, 01 send, 10 register write, 11 register read |
| req_addr | input | 6 | Register address for register operations |
| req_pid | input | 4 | PID for a packet send |
| req_ready | output | 1 | Request consumed in this cycle |
| dat_valid | input | 1 | Payload byte present |
| dat_byte | input | 8 | Payload byte |
| dat_last | input | 1 | Marks the final payload byte |
| dat_ready | output | 1 | Payload byte consumed in this cycle |
| rd_valid | output | 1 | Register read result strobe |
| rd_data | output | 8 | Register read result |
| ulpi_dir | input | 1 | PHY bus ownership |
| ulpi_nxt | input | 1 | PHY accept / throttle |
| ulpi_din | input | 8 | Bus value driven by the PHY |
| ulpi_dout | output | 8 | Bus value driven by the link |
| ulpi_oe | output | 1 | Link output enable for the bus pads |
| ulpi_stp | output | 1 | End of link transfer |

## Verification
The assertions assume the PHY raises `dir` only while the engine is idle or while a command waits for acceptance, never during a payload burst. After accepting a read command, the PHY raises `dir` and keeps it high for the turnaround and data cycles. The assertions also assume the client keeps `dat_valid` high from the request until the last byte is consumed. The stimulus respects these assumptions. The PHY model injects receive bursts only from its idle state, either unprompted or in place of accepting a waiting command. The bench source loads every payload byte before it raises the request. Random `nxt` stalls, receive bursts that abort commands, and back-to-back requests exercise the pacing, turnaround and retry paths.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SEND  = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } link_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_DATA,
    S_STOP,
    S_RD_TA,
    S_RD_DAT,
    S_RD_END
  } link_state_e;

endpackage

// File: rtl/ulpi_turnaround.sv
module ulpi_turnaround (
  input  logic clk,
  input  logic rst,
  input  logic dir,
  output logic oe_q,
  output logic bus_free
);

  logic dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      dir_q <= dir;
      oe_q  <= !dir;
    end
  end

  // bus usable only after dir was low for a whole cycle
  assign bus_free = !dir && !dir_q;

  a_r8_release_after_dir : assert property (@(posedge clk) disable iff (rst)
    $past(dir) |-> !oe_q);

  a_r9_free_means_driving : assert property (@(posedge clk) disable iff (rst)
    bus_free |-> oe_q);

endmodule

// File: rtl/ulpi_rd_capture.sv
module ulpi_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= din;
    end
  end

  a_r7_single_strobe : assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/ulpi_link_fsm.sv
module ulpi_link_fsm
  import ulpi_link_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [DW-AW-1:0] req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [PW-1:0] req_pid,
  input  logic          dat_valid,
  input  logic [DW-1:0] dat_byte,
  input  logic          dat_last,
  input  logic          dir,
  input  logic          nxt,
  input  logic          bus_free,
  output logic          req_ready,
  output logic          dat_ready,
  output logic [DW-1:0] bus_data,
  output logic          stp,
  output logic          rd_capture
);

  localparam int OPW   = DW - AW;
  localparam int PAD_W = AW - PW;

  link_state_e   state;
  link_op_e      op_q;
  link_op_e      op_in;
  logic [DW-1:0] data_q;
  logic [DW-1:0] cmd_word;
  logic          last_q;
  logic          stp_q;
  logic          accept;
  logic          can_start;

  assign op_in = link_op_e'(req_op);

  // command byte: operation in the top bits, address or PID below
  always_comb begin
    if (op_in == OP_SEND) cmd_word = {req_op, {PAD_W{1'b0}}, req_pid};
    else                  cmd_word = {req_op, req_addr};
  end

  assign accept    = (state == S_CMD) && !dir && nxt;
  assign can_start = req_valid && bus_free && (op_in != OP_NONE) &&
                     (op_in == OP_READ || dat_valid);

  assign req_ready = accept ||
                     ((state == S_IDLE) && req_valid && (op_in == OP_NONE));
  assign dat_ready = (accept && (op_q != OP_READ)) ||
                     ((state == S_DATA) && nxt && !last_q);

  assign bus_data   = data_q;
  assign stp        = stp_q;
  assign rd_capture = (state == S_RD_DAT) && dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      op_q   <= OP_NONE;
      data_q <= '0;
      last_q <= 1'b0;
      stp_q  <= 1'b0;
    end else begin
      stp_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (can_start) begin
            state  <= S_CMD;
            data_q <= cmd_word;
            op_q   <= op_in;
          end
        end
        S_CMD: begin
          if (dir) begin
            state  <= S_IDLE;
            data_q <= '0;
          end else if (nxt) begin
            if (op_q == OP_READ) begin
              state  <= S_RD_TA;
              data_q <= '0;
            end else begin
              state  <= S_DATA;
              data_q <= dat_byte;
              last_q <= dat_last;
            end
          end
        end
        S_DATA: begin
          if (nxt) begin
            if (last_q) begin
              state  <= S_STOP;
              data_q <= '0;
              stp_q  <= 1'b1;
            end else begin
              data_q <= dat_byte;
              last_q <= dat_last;
            end
          end
        end
        S_STOP:   state <= S_IDLE;
        S_RD_TA:  if (dir) state <= S_RD_DAT;
        S_RD_DAT: state <= dir ? S_RD_END : S_IDLE;
        S_RD_END: if (!dir) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  a_r3_cmd_hold : assert property (@(posedge clk) disable iff (rst)
    (state == S_CMD && !dir && !nxt) |=> (state == S_CMD && $stable(data_q)));

  a_r4_data_hold : assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && !nxt) |=> $stable(data_q));

  a_r5_stp_single : assert property (@(posedge clk) disable iff (rst)
    stp_q |=> !stp_q);

  a_r5_stp_after_last : assert property (@(posedge clk) disable iff (rst)
    $rose(stp_q) |-> $past(state == S_DATA && nxt && last_q));

  a_r9_start_when_free : assert property (@(posedge clk) disable iff (rst)
    (state == S_CMD && $past(state) == S_IDLE) |-> $past(bus_free));

  a_r10_abort_clears : assert property (@(posedge clk) disable iff (rst)
    (state == S_CMD && dir) |=> (state == S_IDLE && data_q == '0));

  a_r11_idle_op_quiet : assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !can_start) |=> (data_q == '0));

endmodule

// File: rtl/ulpi_link_tx.sv
module ulpi_link_tx #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [DW-AW-1:0] req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [PW-1:0] req_pid,
  output logic          req_ready,
  input  logic          dat_valid,
  input  logic [DW-1:0] dat_byte,
  input  logic          dat_last,
  output logic          dat_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          ulpi_dir,
  input  logic          ulpi_nxt,
  input  logic [DW-1:0] ulpi_din,
  output logic [DW-1:0] ulpi_dout,
  output logic          ulpi_oe,
  output logic          ulpi_stp
);

  logic oe_q;
  logic bus_free;
  logic rd_capture;

  ulpi_turnaround u_turn (
    .clk      (clk),
    .rst      (rst),
    .dir      (ulpi_dir),
    .oe_q     (oe_q),
    .bus_free (bus_free)
  );

  ulpi_link_fsm #(.DW(DW), .AW(AW), .PW(PW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_pid    (req_pid),
    .dat_valid  (dat_valid),
    .dat_byte   (dat_byte),
    .dat_last   (dat_last),
    .dir        (ulpi_dir),
    .nxt        (ulpi_nxt),
    .bus_free   (bus_free),
    .req_ready  (req_ready),
    .dat_ready  (dat_ready),
    .bus_data   (ulpi_dout),
    .stp        (ulpi_stp),
    .rd_capture (rd_capture)
  );

  ulpi_rd_capture #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .capture  (rd_capture),
    .din      (ulpi_din),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // release the pads in the very cycle dir rises
  assign ulpi_oe = oe_q && !ulpi_dir;

  a_r8_no_contention : assert property (@(posedge clk) disable iff (rst)
    $past(ulpi_dir) |-> (ulpi_dout == '0));

endmodule

// File: tb/ulpi_link_tx_bench.sv
module ulpi_link_tx_bench;

  localparam int M_IDLE = 0, M_DATA = 1, M_RDTA = 2, M_RDD = 3, M_RDE = 4, M_RX = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [5:0] req_addr = '0;
  logic [3:0] req_pid = '0;
  logic       req_ready;
  logic       dat_valid = 1'b0;
  logic [7:0] dat_byte = '0;
  logic       dat_last = 1'b0;
  logic       dat_ready;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       ulpi_dir = 1'b0;
  logic       ulpi_nxt = 1'b0;
  logic [7:0] ulpi_din = '0;
  logic [7:0] ulpi_dout;
  logic       ulpi_oe;
  logic       ulpi_stp;

  ulpi_link_tx u_ulpi_link_tx (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_pid(req_pid),
    .req_ready(req_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_last(dat_last), .dat_ready(dat_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_din(ulpi_din),
    .ulpi_dout(ulpi_dout), .ulpi_oe(ulpi_oe), .ulpi_stp(ulpi_stp)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expectations owned by the bench
  logic [7:0] shadow [64];
  logic [7:0] exp_pkt [$];
  logic [7:0] exp_cmd;
  logic [7:0] src_bytes [16];

  // PHY model state
  logic [7:0] mregs [64];
  logic [7:0] act_pkt [$];
  int         mst;
  int         rxcnt;
  int         stp_cnt;
  int         n_abort;
  bit         abort_en;
  bit         spont_en;
  bit         prev2_dir;
  bit         was_stalled;
  bit         retry_pending;
  logic [7:0] stalled_cmd;
  logic [7:0] retry_cmd;
  logic [7:0] prev_out;
  logic [1:0] mop;
  logic [5:0] maddr;
  bit         pd, pn;
  int         r;
  bit         pkt_ok;

  always @(negedge clk) begin
    if (rst) begin
      ulpi_dir = 1'b0; ulpi_nxt = 1'b0; ulpi_din = '0;
      mst = M_IDLE; rxcnt = 0; prev2_dir = 1'b1; was_stalled = 1'b0;
      retry_pending = 1'b0; prev_out = '0;
    end else begin
      pd = ulpi_dir;
      pn = ulpi_nxt;
      if (pd) chk(!ulpi_oe && ulpi_dout == 8'h00, "R8 bus released after dir", {ulpi_oe, ulpi_dout}, 0);
      case (mst)
        M_IDLE: begin
          ulpi_nxt = 1'b0;
          chk(!ulpi_stp, "R5 stp one cycle", ulpi_stp, 0);
          if (ulpi_oe && ulpi_dout[7:6] != 2'b00) begin
            if (prev_out == 8'h00) begin
              chk(!pd && !prev2_dir, "R9 start after free bus", {pd, prev2_dir}, 0);
              chk(ulpi_dout == exp_cmd, "R2 command byte", ulpi_dout, exp_cmd);
              if (retry_pending) begin
                chk(ulpi_dout == retry_cmd, "R10 retried command", ulpi_dout, retry_cmd);
                retry_pending = 1'b0;
              end
            end else if (was_stalled) begin
              chk(ulpi_dout == stalled_cmd, "R3 command held", ulpi_dout, stalled_cmd);
            end
            r = $urandom % 8;
            if (abort_en && r == 0) begin
              ulpi_dir = 1'b1; ulpi_din = 8'h4A; rxcnt = $urandom % 3; mst = M_RX;
              retry_pending = 1'b1; retry_cmd = ulpi_dout; was_stalled = 1'b0; n_abort++;
            end else if (r < 3) begin
              was_stalled = 1'b1; stalled_cmd = ulpi_dout;
            end else begin
              ulpi_nxt = 1'b1; was_stalled = 1'b0;
              mop = ulpi_dout[7:6]; maddr = ulpi_dout[5:0];
              if (mop == 2'b01) begin
                act_pkt.delete();
                act_pkt.push_back({~ulpi_dout[3:0], ulpi_dout[3:0]});
              end
              mst = (mop == 2'b11) ? M_RDTA : M_DATA;
            end
          end else if (spont_en && ($urandom % 16) == 0) begin
            ulpi_dir = 1'b1; ulpi_din = 8'h4E; rxcnt = $urandom % 3; mst = M_RX;
          end
        end
        M_DATA: begin
          if (ulpi_stp) begin
            chk(pn && ulpi_dout == 8'h00, "R5 stp after accepted last byte", {pn, ulpi_dout}, 9'h100);
            ulpi_nxt = 1'b0;
            if (mop == 2'b01) begin
              pkt_ok = (act_pkt.size() == exp_pkt.size());
              if (pkt_ok) foreach (act_pkt[i]) if (act_pkt[i] != exp_pkt[i]) pkt_ok = 1'b0;
              chk(pkt_ok, "R4 R2 transmitted packet stream", act_pkt.size(), exp_pkt.size());
            end
            stp_cnt++;
            mst = M_IDLE;
          end else begin
            if (!pn) chk(ulpi_dout == prev_out, "R4 byte held while nxt low", ulpi_dout, prev_out);
            if (($urandom % 4) != 0) begin
              ulpi_nxt = 1'b1;
              if (mop == 2'b01) act_pkt.push_back(ulpi_dout);
              else begin mregs[maddr] = ulpi_dout; maddr = maddr + 6'd1; end
            end else ulpi_nxt = 1'b0;
          end
        end
        M_RDTA: begin ulpi_nxt = 1'b0; ulpi_dir = 1'b1; ulpi_din = 8'h00; mst = M_RDD; end
        M_RDD:  begin ulpi_din = mregs[maddr]; mst = M_RDE; end
        M_RDE:  begin ulpi_dir = 1'b0; ulpi_din = 8'h00; mst = M_IDLE; end
        M_RX: begin
          if (rxcnt == 0) begin ulpi_dir = 1'b0; mst = M_IDLE; end
          else begin rxcnt--; ulpi_din = 8'h4A; end
        end
        default: mst = M_IDLE;
      endcase
      prev2_dir = pd;
      prev_out  = ulpi_dout;
    end
  end

  // client side: sample handshakes late in the cycle, update just after the edge
  task automatic run_txn(input logic [1:0] op, input logic [5:0] addr, input logic [3:0] pid, input int len);
    int  idx = 0;
    int  nsamp = 0;
    int  stp0 = stp_cnt;
    bit  taken = 1'b0;
    bit  got_rd = 1'b0;
    bit  fin = 1'b0;
    bit  rr, dr, rv;
    logic [7:0] rdd;
    logic [7:0] exp_rd;
    exp_rd = shadow[addr];
    if (op == 2'b01) begin
      exp_pkt.delete();
      exp_pkt.push_back({~pid, pid});
      for (int i = 0; i < len; i++) exp_pkt.push_back(src_bytes[i]);
      exp_cmd = {2'b01, 2'b00, pid};
    end else begin
      exp_cmd = {op, addr};
      if (op == 2'b10) for (int i = 0; i < len; i++) shadow[(addr + i) % 64] = src_bytes[i];
    end
    req_valid = 1'b1; req_op = op; req_addr = addr; req_pid = pid;
    dat_valid = (len > 0); dat_byte = src_bytes[0]; dat_last = (len == 1);
    while (!fin) begin
      @(negedge clk); #5;
      nsamp++;
      rr = req_ready; dr = dat_ready && dat_valid; rv = rd_valid; rdd = rd_data;
      if (rv) begin
        chk(op == 2'b11 && rdd == exp_rd, "R7 R6 read data", rdd, exp_rd);
        got_rd = 1'b1;
      end
      if (op == 2'b00 && nsamp == 1) chk(rr, "R11 idle op consumed at once", rr, 1);
      @(posedge clk); #1;
      if (rr) begin req_valid = 1'b0; taken = 1'b1; end
      if (dr) begin
        idx++;
        if (idx < len) begin dat_byte = src_bytes[idx]; dat_last = (idx == len - 1); end
        else begin dat_valid = 1'b0; dat_last = 1'b0; end
      end
      case (op)
        2'b00:   fin = taken;
        2'b11:   fin = got_rd;
        default: fin = taken && (idx == len) && (stp_cnt != stp0);
      endcase
    end
    if (op == 2'b00) begin
      repeat (2) begin
        @(negedge clk); #5;
        chk(ulpi_dout == 8'h00 && !ulpi_stp, "R11 bus stays idle", ulpi_dout, 0);
      end
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    for (int i = 0; i < 64; i++) begin shadow[i] = 8'h00; mregs[i] = 8'h00; end
    stp_cnt = 0; n_abort = 0; abort_en = 1'b0; spont_en = 1'b0; exp_cmd = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    chk(ulpi_dout == 8'h00, "R1 reset bus data", ulpi_dout, 0);
    chk(!ulpi_oe && !ulpi_stp, "R1 reset oe and stp", {ulpi_oe, ulpi_stp}, 0);
    chk(!req_ready && !rd_valid, "R1 reset strobes", {req_ready, rd_valid}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(posedge clk); #1;

    // directed corners
    run_txn(2'b00, 6'd0, 4'd0, 0);                                   // R11
    src_bytes[0] = 8'hA1; src_bytes[1] = 8'hB2; src_bytes[2] = 8'hC3;
    run_txn(2'b10, 6'd5, 4'd0, 3);                                   // R6 multi-byte write
    run_txn(2'b11, 6'd5, 4'd0, 0);                                   // R7
    run_txn(2'b11, 6'd6, 4'd0, 0);
    run_txn(2'b11, 6'd7, 4'd0, 0);
    src_bytes[0] = 8'h5A;
    run_txn(2'b01, 6'd0, 4'h3, 1);                                   // R2 single-byte packet
    src_bytes[0] = 8'h11; src_bytes[1] = 8'h22;
    run_txn(2'b10, 6'd62, 4'd0, 2);                                  // R6 top addresses
    run_txn(2'b11, 6'd63, 4'd0, 0);

    // random traffic with stalls, receive bursts and command aborts (R3 R4 R9 R10)
    abort_en = 1'b1; spont_en = 1'b1;
    for (int t = 0; t < 150; t++) begin
      int op;
      int len;
      logic [5:0] a;
      op = ($urandom % 3) + 1;
      len = (op == 1) ? 1 + ($urandom % 8) : (op == 2) ? 1 + ($urandom % 4) : 0;
      a = 6'($urandom % 60);
      for (int i = 0; i < 16; i++) src_bytes[i] = 8'($urandom);
      run_txn(2'(op), a, 4'($urandom), len);
      repeat ($urandom % 3) @(posedge clk);
      #1;
    end
    chk(n_abort > 0, "R10 aborts exercised", n_abort, 1);

    // read everything back through the engine (R6 R7)
    for (int a = 0; a < 64; a++) run_txn(2'b11, 6'(a), 4'd0, 0);
    for (int a = 0; a < 64; a++) chk(mregs[a] == shadow[a], "R6 PHY register contents", mregs[a], shadow[a]);

    done_flag = 1'b1;
    finish_run();
  end

endmodule